// File: doc/BRIEF.md
# Branch Resolution and Delay-Slot Unit

This unit resolves three conditional PC-relative branches for a 32-bit RISC pipeline that has one architectural delay slot. Each cycle in which `in_valid` is high, it takes a fetched instruction word, that instruction's PC and the two register operand values read for it. One clock later it reports the result. The result holds a redirect flag and the target address. It also holds a request to write the return address into register 31, a request to cancel the delay-slot instruction, and a flag for placements the pipeline must not resolve.

The three branches are an equal-compare branch of the "likely" kind, a sign test that branches when rs is not negative, and the same sign test with a link write. For the likely form, the delay-slot instruction runs only when the branch is taken. When it is not taken, the unit asks the pipeline to cancel that instruction. For the other two, the slot instruction always runs. The linking form writes its return address whether or not it branches.

The unit keeps its own record of whether the next valid instruction occupies a delay slot. A branch arriving in that position is flagged, not resolved. The linking branch with register 31 as its source is flagged in the same way.

Top module: `brdelay_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid, out_taken, out_nullify, out_link_we and out_illegal are all 0.
- R2: Bits 31:26 of the instruction are the primary opcode, 25:21 the rs index, 20:16 the rt field and 15:0 the offset. Opcode 6'b010100 is the equal-likely branch. Opcode 6'b000001 with rt field 5'b00001 is the sign-test branch, and with rt field 5'b10001 it is the linking sign-test branch. Any other word gives out_taken, out_nullify, out_link_we and out_illegal all 0, with out_target, out_link_val and out_link_idx at 0.
- R3: The outputs for an input sampled with in_valid high appear in the next cycle, with out_valid high. A cycle after in_valid was low shows out_valid low and out_taken, out_nullify and out_link_we low.
- R4: For every legal branch, out_target equals in_pc + 4 + (the 16-bit offset shifted left by 2 and sign-extended from 18 bits), modulo 2^32, whether or not the branch is taken.
- R5: The equal-likely branch sets out_taken exactly when the rs and rt operands are bitwise equal. It sets out_nullify exactly when they differ.
- R6: The sign-test branch and its linking form set out_taken exactly when bit 31 of the rs operand is 0, and never set out_nullify.
- R7: The linking sign-test branch, when legal, sets out_link_we whether taken or not, with out_link_idx = 31 and out_link_val = in_pc + 8 modulo 2^32.
- R8: A recognised branch that arrives as the next valid input after a legal branch (its delay slot) sets out_illegal and clears out_taken, out_nullify and out_link_we.
- R9: The linking sign-test branch whose rs field is 31 sets out_illegal, does not write the link register and is not taken.
- R10: Only a legal branch opens a delay slot. After an illegal branch, or after the single instruction in a slot, the next branch resolves normally. Idle cycles do not close a pending slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 32 | Fetched instruction word |
| in_pc | input | 32 | Address of that instruction |
| in_rs_val | input | 32 | Value of the rs operand |
| in_rt_val | input | 32 | Value of the rt operand |
| out_valid | output | 1 | Result present this cycle |
| out_taken | output | 1 | Redirect to out_target after the slot |
| out_target | output | 32 | Branch target address |
| out_nullify | output | 1 | Cancel the delay-slot instruction |
| out_link_we | output | 1 | Write the return address |
| out_link_idx | output | 5 | Register written (31) |
| out_link_val | output | 32 | Return address |
| out_illegal | output | 1 | Branch placement or encoding not resolvable |

## Verification
The equal-likely branch is driven with equal operands and with operands that differ in a single high bit. This shows that the compare covers every lane of the word and that the taken and nullify outcomes are complementary. The sign test is given zero, positive and most-negative rs values. Offsets 0x7FFF, 0x8000 and small values of both signs, with PCs near the top and bottom of the address space, expose sign-extension and wrap errors in the target and link sums. Back-to-back branch sequences, separated by idle cycles, an illegal branch or a filler instruction, tell apart a correct delay-slot tracker from one that never closes, never opens or is reset by idle cycles. A run of random words then covers the decoder.

// File: rtl/brdelay_pkg.sv
package brdelay_pkg;
    parameter int unsigned XLEN   = 32;
    parameter int unsigned REG_W  = 5;
    parameter int unsigned OFF_W  = 16;
    parameter int unsigned OP_W   = 6;
    localparam int unsigned EXT_W = XLEN - OFF_W - 2;

    localparam logic [OP_W-1:0]  OP_EQ_LIKELY = 6'b010100;
    localparam logic [OP_W-1:0]  OP_REGIMM    = 6'b000001;
    localparam logic [REG_W-1:0] SUB_GEZ      = 5'b00001;
    localparam logic [REG_W-1:0] SUB_GEZ_LINK = 5'b10001;
    localparam logic [REG_W-1:0] LINK_IDX     = 5'd31;

    typedef enum logic [1:0] {
        BR_NONE,
        BR_EQL,
        BR_GEZ,
        BR_GEZAL
    } br_kind_e;

    typedef struct packed {
        logic             valid;
        logic             taken;
        logic             nullify;
        logic             link_we;
        logic             illegal;
        logic [XLEN-1:0]  target;
        logic [XLEN-1:0]  link_val;
        logic [REG_W-1:0] link_idx;
        logic             slot;
    } unit_state_t;
endpackage

// File: rtl/brdelay_decode.sv
module brdelay_decode
    import brdelay_pkg::*;
(
    input  logic [XLEN-1:0]  instr,
    output br_kind_e         kind,
    output logic [REG_W-1:0] rs_idx,
    output logic [OFF_W-1:0] offset
);
    localparam int unsigned OP_LO = XLEN - OP_W;
    localparam int unsigned RS_LO = OP_LO - REG_W;
    localparam int unsigned RT_LO = RS_LO - REG_W;

    logic [OP_W-1:0]  opcode;
    logic [REG_W-1:0] rt_field;

    always_comb begin
        opcode   = instr[XLEN-1:OP_LO];
        rs_idx   = instr[OP_LO-1:RS_LO];
        rt_field = instr[RS_LO-1:RT_LO];
        offset   = instr[OFF_W-1:0];
        kind     = BR_NONE;
        if (opcode == OP_EQ_LIKELY) begin
            kind = BR_EQL;
        end else if (opcode == OP_REGIMM) begin
            if (rt_field == SUB_GEZ)           kind = BR_GEZ;
            else if (rt_field == SUB_GEZ_LINK) kind = BR_GEZAL;
        end
    end
endmodule

// File: rtl/brdelay_cond.sv
module brdelay_cond
    import brdelay_pkg::*;
#(
    parameter int unsigned LANE_W = 8
) (
    input  br_kind_e        kind,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            cond
);
    localparam int unsigned LANES = XLEN / LANE_W;

    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (rs_val[g*LANE_W +: LANE_W] == rt_val[g*LANE_W +: LANE_W]);
    end

    always_comb begin
        unique case (kind)
            BR_EQL:          cond = &lane_eq;
            BR_GEZ, BR_GEZAL: cond = ~rs_val[XLEN-1];
            default:         cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/brdelay_addr.sv
module brdelay_addr
    import brdelay_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  link_val
);
    logic [XLEN-1:0] slot_pc;
    logic [XLEN-1:0] disp;

    always_comb begin
        slot_pc  = pc + XLEN'(4);
        disp     = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
        target   = slot_pc + disp;
        link_val = pc + XLEN'(8);
    end
endmodule

// File: rtl/brdelay_unit.sv
module brdelay_unit
    import brdelay_pkg::*;
#(
    parameter int unsigned CMP_LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [XLEN-1:0]         in_instr,
    input  logic [XLEN-1:0]         in_pc,
    input  logic [XLEN-1:0]         in_rs_val,
    input  logic [XLEN-1:0]         in_rt_val,
    output logic                    out_valid,
    output logic                    out_taken,
    output logic [XLEN-1:0]         out_target,
    output logic                    out_nullify,
    output logic                    out_link_we,
    output logic [REG_W-1:0]        out_link_idx,
    output logic [XLEN-1:0]         out_link_val,
    output logic                    out_illegal
);
    br_kind_e         kind;
    logic [REG_W-1:0] rs_idx;
    logic [OFF_W-1:0] offset;
    logic             cond;
    logic [XLEN-1:0]  tgt;
    logic [XLEN-1:0]  ret_addr;
    logic             bad_place;
    unit_state_t      st_d, st_q;

    brdelay_decode u_decode (
        .instr  (in_instr),
        .kind   (kind),
        .rs_idx (rs_idx),
        .offset (offset)
    );

    brdelay_cond #(.LANE_W(CMP_LANE_W)) u_cond (
        .kind   (kind),
        .rs_val (in_rs_val),
        .rt_val (in_rt_val),
        .cond   (cond)
    );

    brdelay_addr u_addr (
        .pc       (in_pc),
        .offset   (offset),
        .target   (tgt),
        .link_val (ret_addr)
    );

    always_comb begin
        bad_place = st_q.slot || (kind == BR_GEZAL && rs_idx == LINK_IDX);
        st_d      = '0;
        st_d.slot = st_q.slot;
        if (in_valid) begin
            st_d.valid = 1'b1;
            st_d.slot  = 1'b0;
            if (kind != BR_NONE) begin
                if (bad_place) begin
                    st_d.illegal = 1'b1;
                end else begin
                    st_d.target  = tgt;
                    st_d.taken   = cond;
                    st_d.nullify = (kind == BR_EQL) && !cond;
                    st_d.slot    = 1'b1;
                    if (kind == BR_GEZAL) begin
                        st_d.link_we  = 1'b1;
                        st_d.link_val = ret_addr;
                        st_d.link_idx = LINK_IDX;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign out_taken    = st_q.taken;
    assign out_target   = st_q.target;
    assign out_nullify  = st_q.nullify;
    assign out_link_we  = st_q.link_we;
    assign out_link_idx = st_q.link_idx;
    assign out_link_val = st_q.link_val;
    assign out_illegal  = st_q.illegal;
endmodule

// File: rtl/brdelay_unit_chk.sv
module brdelay_unit_chk
    import brdelay_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [XLEN-1:0]  in_instr,
    input logic [XLEN-1:0]  in_pc,
    input logic             out_valid,
    input logic             out_taken,
    input logic [XLEN-1:0]  out_target,
    input logic             out_nullify,
    input logic             out_link_we,
    input logic [REG_W-1:0] out_link_idx,
    input logic [XLEN-1:0]  out_link_val,
    input logic             out_illegal
);
    // R3
    strobe_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_taken && !out_nullify && !out_link_we));

    // R5
    nullify_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_nullify |-> !out_taken);

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_taken && !out_nullify && !out_link_we));

    // R7
    link_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> (out_link_val == $past(in_pc) + XLEN'(8) && out_link_idx == LINK_IDX));

    // R4
    target_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_taken |-> (out_target == $past(in_pc) + XLEN'(4)
            + {{EXT_W{$past(in_instr[OFF_W-1])}}, $past(in_instr[OFF_W-1:0]), 2'b00}));
endmodule

bind brdelay_unit brdelay_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_instr     (in_instr),
    .in_pc        (in_pc),
    .out_valid    (out_valid),
    .out_taken    (out_taken),
    .out_target   (out_target),
    .out_nullify  (out_nullify),
    .out_link_we  (out_link_we),
    .out_link_idx (out_link_idx),
    .out_link_val (out_link_val),
    .out_illegal  (out_illegal)
);

// File: tb/brdelay_unit_test.sv
`timescale 1ns/1ps
module brdelay_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0, in_pc = '0, in_rs_val = '0, in_rt_val = '0;
    logic        out_valid, out_taken, out_nullify, out_link_we, out_illegal;
    logic [31:0] out_target, out_link_val;
    logic [4:0]  out_link_idx;

    int total = 0;
    int bad = 0;
    bit model_slot = 0;

    always #4 clk = ~clk;

    brdelay_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_pc(in_pc), .in_rs_val(in_rs_val), .in_rt_val(in_rt_val),
        .out_valid(out_valid), .out_taken(out_taken), .out_target(out_target),
        .out_nullify(out_nullify), .out_link_we(out_link_we),
        .out_link_idx(out_link_idx), .out_link_val(out_link_val),
        .out_illegal(out_illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int rsf, input int rtf, input int off);
        return {op[5:0], rsf[4:0], rtf[4:0], off[15:0]};
    endfunction

    // One strobe preceded by one idle cycle; the model predicts the result.
    task automatic apply(input string req, input logic [31:0] ins, input logic [31:0] pc,
                         input logic [31:0] rs, input logic [31:0] rt);
        int  op, rsf, rtf, kind;
        bit  brn, ill, cnd;
        bit  e_tk, e_nl, e_we, e_il;
        longint tgt_l;
        logic [31:0] e_tg, e_lv, e_li;
        @(negedge clk);
        check("R3", "idle valid", {31'b0, out_valid}, 0);
        check("R3", "idle taken", {31'b0, out_taken | out_nullify | out_link_we}, 0);
        in_valid = 1'b1; in_instr = ins; in_pc = pc; in_rs_val = rs; in_rt_val = rt;
        op = ins[31:26]; rsf = ins[25:21]; rtf = ins[20:16];
        kind = 0;
        if (op == 20) kind = 1;
        else if (op == 1 && rtf == 1) kind = 2;
        else if (op == 1 && rtf == 17) kind = 3;
        brn = (kind != 0);
        ill = brn && (model_slot || (kind == 3 && rsf == 31));
        e_tk = 0; e_nl = 0; e_we = 0; e_il = ill; e_tg = 0; e_lv = 0; e_li = 0;
        if (brn && !ill) begin
            tgt_l = longint'(pc) + 4 + longint'($signed(ins[15:0])) * 4;
            e_tg  = tgt_l[31:0];
            cnd   = (kind == 1) ? (rs == rt) : ($signed(rs) >= 0);
            e_tk  = cnd;
            e_nl  = (kind == 1) && !cnd;
            if (kind == 3) begin
                e_we = 1; e_li = 31;
                tgt_l = longint'(pc) + 8;
                e_lv = tgt_l[31:0];
            end
        end
        model_slot = brn && !ill;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3", "valid", {31'b0, out_valid}, 1);
        check(req, "taken", {31'b0, out_taken}, {31'b0, e_tk});
        check(req, "nullify", {31'b0, out_nullify}, {31'b0, e_nl});
        check(req, "link_we", {31'b0, out_link_we}, {31'b0, e_we});
        check(req, "illegal", {31'b0, out_illegal}, {31'b0, e_il});
        check(req, "target", out_target, e_tg);
        check(req, "link_val", out_link_val, e_lv);
        check(req, "link_idx", {27'b0, out_link_idx}, e_li);
    endtask

    localparam logic [31:0] NOP = 32'h0000_0000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "valid", {31'b0, out_valid}, 0);
        check("R1", "flags", {27'b0, out_taken, out_nullify, out_link_we, out_illegal, 1'b0}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "after reset", {27'b0, out_valid, out_taken, out_nullify, out_link_we, out_illegal}, 0);

        // R2 non-branch words
        apply("R2", NOP, 32'h100, 32'h0, 32'h0);
        apply("R2", mk(1, 3, 0, 16), 32'h104, 32'h0, 32'h0);
        apply("R2", mk(4, 3, 3, 16), 32'h108, 32'h5, 32'h5);
        // R5 equal-likely, equal operands, positive offset
        apply("R5", mk(20, 1, 2, 16'h0010), 32'h1000, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        apply("R2", NOP, 32'h1004, 0, 0);
        // R5 unequal (top lane), offset 0x8000 with wrap below zero (R4)
        apply("R5", mk(20, 1, 2, 16'h8000), 32'h0001_0000, 32'h8000_0001, 32'h0000_0001);
        apply("R2", NOP, 32'h0001_0004, 0, 0);
        apply("R4", mk(20, 1, 2, 16'hFFFF), 32'h40, 32'h7, 32'h7);
        apply("R2", NOP, 32'h44, 0, 0);
        // R6 sign test: zero, positive, negative
        apply("R6", mk(1, 4, 1, 16'h7FFF), 32'h2000, 32'h0, 32'h1);
        apply("R2", NOP, 32'h2004, 0, 0);
        apply("R6", mk(1, 4, 1, 16'h0003), 32'h2100, 32'h5, 32'h0);
        apply("R2", NOP, 32'h2104, 0, 0);
        apply("R6", mk(1, 4, 1, 16'hFFFE), 32'h2200, 32'h8000_0000, 32'h0);
        apply("R2", NOP, 32'h2204, 0, 0);
        // R7 link, not taken, PC wrap; then taken
        apply("R7", mk(1, 6, 17, 16'h0001), 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'h0);
        apply("R2", NOP, 32'h0, 0, 0);
        apply("R7", mk(1, 0, 17, 16'h0020), 32'h3000, 32'h0, 32'h0);
        apply("R2", NOP, 32'h3004, 0, 0);
        // R9 linking with rs=31, then R10: next branch is legal
        apply("R9", mk(1, 31, 17, 16'h0020), 32'h4000, 32'h1, 32'h0);
        apply("R10", mk(1, 2, 1, 16'h0008), 32'h4004, 32'h1, 32'h0);
        // R8 branch in its delay slot, then R10 slot closed
        apply("R8", mk(20, 1, 1, 16'h0004), 32'h4008, 32'h3, 32'h3);
        apply("R10", mk(1, 5, 17, 16'h0004), 32'h400C, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        apply("R8", mk(1, 5, 1, 16'h0004), 32'h4010, 32'h0, 32'h0);

        // random mix, reference model decides each outcome
        for (int i = 0; i < 60; i++) begin
            int sel;
            logic [31:0] w, a, b;
            sel = $urandom_range(0, 4);
            a = $urandom;
            b = ($urandom_range(0, 1) == 1) ? a : $urandom;
            case (sel)
                0: w = mk(20, $urandom_range(0, 31), $urandom_range(0, 31), $urandom);
                1: w = mk(1, $urandom_range(0, 31), 1, $urandom);
                2: w = mk(1, $urandom_range(0, 31), 17, $urandom);
                default: w = $urandom;
            endcase
            apply("R2", w, $urandom & 32'hFFFF_FFFC, a, b);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule